// File: doc/BRIEF.md
# Code-Address Breakpoint Comparator

This block keeps four code-address breakpoint slots for an on-chip debug unit and watches every instruction fetch of the CPU. A debug host programs one slot per configuration strobe. The strobe carries three bytes: a control byte that selects the slot and sets or clears its enable, then the high and the low byte of the 16-bit code address. The three bytes arrive in parallel with one strobe.

On every cycle where the CPU presents a qualified fetch, the fetch address is compared with all enabled slots in parallel. A hit raises a halt request that stays asserted until the debug logic pulses resume. The block also reports which slot caused the halt. When several slots hit, the lowest-numbered one is reported. A control byte with nonzero reserved bits is rejected and flagged for one cycle. A disable write keeps the stored address. It cannot be read back, so it has no effect that can be seen at the ports.

Top module: `bkpt_compare`

## Requirements
- R1: After reset, halt_req and cfg_err are 0 and every slot is disabled, so no fetch halts the CPU until a slot is programmed. This includes a fetch of address 0x0000.
- R2: A legal strobe selects slot cfg_ctrl[4:3]. If cfg_ctrl[2]=1, the slot stores {cfg_addr_hi, cfg_addr_lo} and becomes enabled. The new setting applies to fetches from the cycle after the strobe.
- R3: A legal strobe with cfg_ctrl[2]=0 disables the selected slot, and a fetch of its address no longer halts.
- R4: A strobe with cfg_ctrl[1:0] other than 00 changes no slot. cfg_err is 1 in the cycle after that strobe and 0 in the cycle after any other cycle.
- R5: cfg_ctrl[7:5] have no effect on the write.
- R6: A fetch with fetch_valid=1 whose fetch_addr equals an enabled slot's address sets halt_req at the next clock edge. A fetch with fetch_valid=0 never sets it.
- R7: halt_req stays 1 until resume is sampled high. It is then 0 in the next cycle, even if a matching fetch occurs in the same cycle as resume.
- R8: halt_slot gives the lowest-numbered matching enabled slot, captured when halt_req rises and held while halt_req stays 1.
- R9: The four slots are independent: any combination of enabled slots gives the halt behaviour of R6 and R8 for each stored address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_valid | input | 1 | Configuration strobe, one cycle |
| cfg_ctrl | input | 8 | Control byte: [4:3] slot, [2] enable, [1:0] reserved (must be 00), [7:5] unused |
| cfg_addr_hi | input | 8 | Breakpoint address bits 15:8 |
| cfg_addr_lo | input | 8 | Breakpoint address bits 7:0 |
| fetch_valid | input | 1 | CPU fetch qualifier |
| fetch_addr | input | 16 | CPU code address |
| resume | input | 1 | Clears the halt request |
| halt_req | output | 1 | Sticky halt request |
| halt_slot | output | 2 | Slot that caused the halt |
| cfg_err | output | 1 | One-cycle flag for a rejected strobe |

## Verification
All results appear one clock edge after their cause. A strobe or fetch applied in one cycle shows in halt_req, halt_slot or cfg_err in the following cycle, and a configuration applies to a fetch made in the cycle right after the strobe. The bench drives inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the edge that registers them. Before the next case it pulses resume and confirms that halt_req has cleared. The sweep covers every one of the sixteen enable combinations and compares each result with a reference slot model kept in the bench.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;
    localparam int ADDR_W    = 16;
    localparam int NUM_SLOTS = 4;
    localparam int IDX_W     = $clog2(NUM_SLOTS);
    localparam int CTRL_W    = 8;
    // control byte field positions
    localparam int SEL_LSB   = 3;
    localparam int EN_BIT    = 2;
    localparam int RSV_W     = 2;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } slot_t;

    typedef struct packed {
        logic             halt;
        logic [IDX_W-1:0] slot;
        logic             err;
    } ctl_t;
endpackage

// File: rtl/bkpt_slot.sv
module bkpt_slot #(
    parameter int ADDR_W  = 16,
    parameter int IDX_W   = 2,
    parameter int SLOT_ID = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [IDX_W-1:0]  wr_sel,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              cmp_valid,
    input  logic [ADDR_W-1:0] cmp_addr,
    output logic              hit
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
    } st_t;

    st_t st_d, st_q;
    logic sel_me;

    always_comb begin
        sel_me = wr_valid && (wr_sel == IDX_W'(SLOT_ID));
        st_d   = st_q;
        if (sel_me) begin
            st_d.en = wr_en;
            if (wr_en) st_d.addr = wr_addr;
        end
        hit = st_q.en && cmp_valid && (st_q.addr == cmp_addr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    slot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == IDX_W'(SLOT_ID) && wr_en)
            |=> (st_q.en && st_q.addr == $past(wr_addr)));
    // R3
    slot_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_sel == IDX_W'(SLOT_ID) && !wr_en) |=> !hit);
endmodule

// File: rtl/bkpt_prio.sv
module bkpt_prio #(
    parameter int NUM   = 4,
    parameter int IDX_W = 2
) (
    input  logic [NUM-1:0]   hits,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hits[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

    // R8
    always_comb begin
        if (any) prio_pick_chk: assert (hits[idx]);
    end
endmodule

// File: rtl/bkpt_compare.sv
module bkpt_compare
    import bkpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [CTRL_W-1:0] cfg_ctrl,
    input  logic [7:0]        cfg_addr_hi,
    input  logic [7:0]        cfg_addr_lo,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              resume,
    output logic              halt_req,
    output logic [IDX_W-1:0]  halt_slot,
    output logic              cfg_err
);
    logic                 rsv_bad;
    logic                 wr_ok;
    logic [IDX_W-1:0]     wr_sel;
    logic                 wr_en;
    logic [ADDR_W-1:0]    wr_addr;
    logic [NUM_SLOTS-1:0] hits;
    logic                 any_hit;
    logic [IDX_W-1:0]     hit_idx;
    ctl_t                 ctl_d, ctl_q;

    always_comb begin
        rsv_bad = |cfg_ctrl[RSV_W-1:0];
        wr_ok   = cfg_valid && !rsv_bad;
        wr_sel  = cfg_ctrl[SEL_LSB +: IDX_W];
        wr_en   = cfg_ctrl[EN_BIT];
        wr_addr = {cfg_addr_hi, cfg_addr_lo};
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        bkpt_slot #(
            .ADDR_W (ADDR_W),
            .IDX_W  (IDX_W),
            .SLOT_ID(g)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_valid (wr_ok),
            .wr_sel   (wr_sel),
            .wr_en    (wr_en),
            .wr_addr  (wr_addr),
            .cmp_valid(fetch_valid),
            .cmp_addr (fetch_addr),
            .hit      (hits[g])
        );
    end

    bkpt_prio #(.NUM(NUM_SLOTS), .IDX_W(IDX_W)) u_prio (
        .hits(hits),
        .any (any_hit),
        .idx (hit_idx)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = cfg_valid && rsv_bad;
        if (resume) begin
            ctl_d.halt = 1'b0;
        end else if (!ctl_q.halt && any_hit) begin
            ctl_d.halt = 1'b1;
            ctl_d.slot = hit_idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign halt_req  = ctl_q.halt;
    assign halt_slot = ctl_q.slot;
    assign cfg_err   = ctl_q.err;

    // R4
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && cfg_ctrl[1:0] != 2'b00) |=> cfg_err);
    // R4
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_valid && cfg_ctrl[1:0] != 2'b00) |=> !cfg_err);
    // R6
    halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!resume && fetch_valid && (hits != '0)) |=> halt_req);
    // R6
    no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_req && !fetch_valid) |=> !halt_req);
    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !resume) |=> halt_req);
    // R7
    resume_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resume |=> !halt_req);
    // R8
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_req && !resume) |=> $stable(halt_slot));
endmodule

// File: tb/tb_bkpt_compare.sv
module tb_bkpt_compare;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_valid = 1'b0;
    logic [7:0]  cfg_ctrl = '0;
    logic [7:0]  cfg_addr_hi = '0;
    logic [7:0]  cfg_addr_lo = '0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        resume = 1'b0;
    logic        halt_req;
    logic [1:0]  halt_slot;
    logic        cfg_err;

    int n_chk = 0;
    int n_bad = 0;
    logic        m_en [4];
    logic [15:0] m_addr [4];

    always #2.5 clk = ~clk;

    bkpt_compare dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ctrl(cfg_ctrl),
        .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .resume(resume),
        .halt_req(halt_req), .halt_slot(halt_slot), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic cfg_write(input logic [7:0] ctrl, input logic [15:0] a);
        cfg_valid = 1'b1; cfg_ctrl = ctrl;
        cfg_addr_hi = a[15:8]; cfg_addr_lo = a[7:0];
        @(negedge clk);
        cfg_valid = 1'b0;
        if (ctrl[1:0] == 2'b00) begin
            m_en[ctrl[4:3]] = ctrl[2];
            if (ctrl[2]) m_addr[ctrl[4:3]] = a;
        end
    endtask

    task automatic release_halt();
        resume = 1'b1;
        @(negedge clk);
        resume = 1'b0;
        check("R7 cleared after resume", int'(halt_req), 0);
    endtask

    task automatic fetch_check(input string req, input logic v, input logic [15:0] a);
        bit hit = 0;
        int idx = 0;
        for (int i = 3; i >= 0; i--) begin
            if (m_en[i] && m_addr[i] == a) begin hit = 1; idx = i; end
        end
        if (!v) hit = 0;
        fetch_valid = v; fetch_addr = a;
        @(negedge clk);
        fetch_valid = 1'b0;
        check(req, int'(halt_req), int'(hit));
        if (hit) check({req, " slot"}, int'(halt_slot), idx);
        if (halt_req) release_halt();
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_en[i] = 0; m_addr[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 halt_req", int'(halt_req), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        fetch_check("R1 no halt at 0x0000", 1'b1, 16'h0000);

        // R5: unused bits 7:5 set; slot 2 enabled at 0x2468
        cfg_write(8'b111_10_1_00, 16'h2468);
        fetch_check("R5 unused bits ignored", 1'b1, 16'h2468);

        // R9/R2/R3/R6/R8 sweep over all enable masks
        for (int mask = 0; mask < 16; mask++) begin
            for (int s = 0; s < 4; s++) begin
                logic [15:0] a;
                a = 16'h1000 * 16'(s + 1) + 16'(mask * 17);
                if (mask >= 8 && s == 3) a = 16'h1000 * 16'd2 + 16'(mask * 17);
                cfg_write({3'b000, 2'(s), mask[s], 2'b00}, a);
            end
            for (int s = 0; s < 4; s++) begin
                logic [15:0] a;
                a = 16'h1000 * 16'(s + 1) + 16'(mask * 17);
                fetch_check("R9 R2 R3 R8 sweep fetch", 1'b1, a);
                fetch_check("R6 no fetch_valid", 1'b0, a);
            end
            fetch_check("R6 non-matching addr", 1'b1, 16'hFFFF);
        end

        // R3: disable slot 1 after it was enabled
        cfg_write(8'b000_01_1_00, 16'hABCD);
        fetch_check("R2 slot 1 enabled", 1'b1, 16'hABCD);
        cfg_write(8'b000_01_0_00, 16'h0000);
        fetch_check("R3 slot 1 disabled", 1'b1, 16'hABCD);

        // R4: reserved bits nonzero, write to slot 0 rejected
        cfg_write(8'b000_00_1_00, 16'h5A5A);
        cfg_valid = 1'b1; cfg_ctrl = 8'b000_00_0_01;
        cfg_addr_hi = 8'h00; cfg_addr_lo = 8'h00;
        @(negedge clk);
        cfg_valid = 1'b0;
        check("R4 cfg_err pulse", int'(cfg_err), 1);
        @(negedge clk);
        check("R4 cfg_err one cycle", int'(cfg_err), 0);
        fetch_check("R4 slot 0 unchanged", 1'b1, 16'h5A5A);
        cfg_valid = 1'b1; cfg_ctrl = 8'b000_11_1_10;
        cfg_addr_hi = 8'h77; cfg_addr_lo = 8'h77;
        @(negedge clk);
        cfg_valid = 1'b0;
        check("R4 cfg_err reserved 10", int'(cfg_err), 1);
        fetch_check("R4 rejected enable", 1'b1, 16'h7777);

        // R7/R8 stickiness: slot 3 at 0x3333, slot 0 at 0x5A5A
        cfg_write(8'b000_11_1_00, 16'h3333);
        fetch_valid = 1'b1; fetch_addr = 16'h3333;
        @(negedge clk);
        fetch_addr = 16'h5A5A;
        @(negedge clk);
        fetch_valid = 1'b0;
        check("R7 halt held", int'(halt_req), 1);
        check("R8 slot held while halted", int'(halt_slot), 3);
        repeat (3) @(negedge clk);
        check("R7 halt still held", int'(halt_req), 1);
        // resume with a same-cycle matching fetch
        resume = 1'b1; fetch_valid = 1'b1; fetch_addr = 16'h5A5A;
        @(negedge clk);
        resume = 1'b0; fetch_valid = 1'b0;
        check("R7 resume wins over match", int'(halt_req), 0);
        fetch_check("R8 new halt captures slot 0", 1'b1, 16'h5A5A);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule